// File: doc/BRIEF.md
# Counted Burst Receive Queue

This block takes bytes from a bit-level serial shifter and stores them in a receive queue, one burst at a time. A single write to the control register launches a burst: the low field sets how many bytes to collect and a separate flag asks for the last byte of that burst to be refused (NAK) rather than acknowledged. For each completed byte the block tells the shifter whether to answer ACK or NAK. When the final byte of the burst lands, a sticky completion flag is raised.

Software then drains the queue one byte per pop through the read-out port and clears the completion flag by writing 1 to it. Reads longer than the queue depth are split by software into several bursts. Only the closing burst sets the NAK flag, so all earlier bursts acknowledge every byte. The start and address phases and the bus timing belong to the shifter and are not part of this block.

Top module: `rxq_burst_rx`

## Requirements
- R1: After reset the burst engine is idle (`rx_busy` = 0), the status word is all zero, and `fifo_status` shows only the empty flag at bit 2.
- R2: A control write with a count of N in bits 6:0 (1 to 64), made while idle, sets `rx_busy` from the next cycle. The engine then takes exactly N bytes, each built from 8 serial bits with the most significant bit first, and returns to idle after the Nth byte.
- R3: Each byte completes with one `ack_strobe` pulse. `ack_is_nak` is 1 only on the final byte of a burst whose control write had bit 7 set. Every other byte is acknowledged (`ack_is_nak` = 0).
- R4: Bit 4 of `status` is set in the cycle after the final byte of a burst. It stays set until a status write with bit 4 = 1 clears it. A status write with bit 4 = 0 leaves it set.
- R5: Each pop returns the oldest byte in the queue on `pop_data` and removes it. Bit 2 of `fifo_status` is 1 exactly when the queue holds no bytes.
- R6: A pop on an empty queue returns 0 and does not move the queue, so later bytes come out in order.
- R7: A control write with a count of 0 starts nothing. `rx_busy` stays 0 and no completion flag is raised.
- R8: A count above the queue depth (65 to 127) is treated as a count equal to the depth.
- R9: A control write made while a burst is running is ignored. The running burst keeps its count and its NAK setting.
- R10: A byte that completes while the queue is full is discarded but still counted, so the burst still ends and still raises the completion flag. The bytes already in the queue are unchanged.
- R11: Serial bits presented while the engine is idle are ignored. No strobe is given and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control data: count in bits 6:0, NAK-last request in bit 7 |
| stat_wr | input | 1 | Status register write strobe (write 1 to clear) |
| stat_wdata | input | 8 | Status write data, bit 4 clears the completion flag |
| status | output | 8 | Status word, completion flag at bit 4 |
| fifo_status | output | 8 | Queue status word, empty flag at bit 2 |
| pop | input | 1 | Remove one byte from the queue |
| pop_data | output | 8 | Oldest queued byte (0 when the queue is empty) |
| bit_vld | input | 1 | Shifter presents one received bit |
| bit_val | input | 1 | Value of the presented bit |
| rx_busy | output | 1 | Burst in progress, the shifter should clock bits in |
| ack_strobe | output | 1 | A byte has just completed |
| ack_is_nak | output | 1 | Answer for the completed byte: 1 = NAK, 0 = ACK |

## Verification
The bench builds the block with its default values: a queue depth of 64, 8-bit data and 8-bit register words, with the NAK flag, the completion flag and the empty flag at their stated positions. With these values a single clamped burst of 64 bytes fills the queue to the brim. A second burst launched on top of it then reaches the discard path, and draining 64 bytes checks that the first burst came through intact. Depth-sized bursts also drive the queue pointers through a full wrap, so the ordering checks cover the wrap point.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Burst length after limiting the request to the queue depth.
  function automatic int unsigned clamp_len(int unsigned req, int unsigned depth);
    return (req > depth) ? depth : req;
  endfunction

  // A byte is refused only when it closes a burst that asked for it.
  function automatic logic nak_due(int unsigned left, logic nak_req);
    return nak_req && (left == 1);
  endfunction

  // Circular index step over a queue of the given depth.
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/rxq_shift.sv
module rxq_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          bit_vld,
  input  logic          bit_val,
  output logic          byte_done,
  output logic [DW-1:0] byte_data
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [BW-1:0] bit_cnt;
  logic [DW-2:0] acc;

  assign byte_done = busy && bit_vld && (bit_cnt == BW'(DW - 1));
  assign byte_data = {acc, bit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      acc     <= '0;
    end else if (!busy) begin
      bit_cnt <= '0;
    end else if (bit_vld) begin
      bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
      acc     <= {acc[DW-3:0], bit_val};
    end
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              rd_data,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  import rxq_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rd_data = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= AW'(wrap_inc(int'(wptr), DEPTH));
      if (pop_ok)  rptr <= AW'(wrap_inc(int'(rptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH   = 64,
  parameter int FIELD_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       launch,
  input  logic [FIELD_W-1:0]         req_cnt,
  input  logic                       req_nak,
  input  logic                       byte_done,
  output logic                       busy,
  output logic [$clog2(DEPTH+1)-1:0] remain,
  output logic                       nak_now,
  output logic                       last_byte
);
  import rxq_pkg::*;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic nak_en;
  logic launch_ok;

  assign launch_ok = launch && !busy && (req_cnt != '0);
  assign last_byte = byte_done && (remain == CNT_W'(1));
  assign nak_now   = nak_due(int'(remain), nak_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
      nak_en <= 1'b0;
    end else if (launch_ok) begin
      busy   <= 1'b1;
      remain <= CNT_W'(clamp_len(int'(req_cnt), DEPTH));
      nak_en <= req_nak;
    end else if (byte_done) begin
      remain <= remain - 1'b1;
      if (last_byte) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_burst_rx.sv
module rxq_burst_rx #(
  parameter int DEPTH     = 64,
  parameter int DW        = 8,
  parameter int REG_W     = 8,
  parameter int NAK_BIT   = 7,
  parameter int DONE_BIT  = 4,
  parameter int EMPTY_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             stat_wr,
  input  logic [REG_W-1:0] stat_wdata,
  output logic [REG_W-1:0] status,
  output logic [REG_W-1:0] fifo_status,
  input  logic             pop,
  output logic [DW-1:0]    pop_data,
  input  logic             bit_vld,
  input  logic             bit_val,
  output logic             rx_busy,
  output logic             ack_strobe,
  output logic             ack_is_nak
);
  localparam int FIELD_W = NAK_BIT;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  // Internal events, named for the checker
  logic             busy;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] level;
  logic             byte_done;
  logic [DW-1:0]    byte_data;
  logic             last_byte;
  logic             nak_now;
  logic             q_empty;
  logic             done_q;

  rxq_ctrl #(.DEPTH(DEPTH), .FIELD_W(FIELD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (ctl_wr),
    .req_cnt   (ctl_wdata[FIELD_W-1:0]),
    .req_nak   (ctl_wdata[NAK_BIT]),
    .byte_done (byte_done),
    .busy      (busy),
    .remain    (remain),
    .nak_now   (nak_now),
    .last_byte (last_byte)
  );

  rxq_shift #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .byte_done (byte_done),
    .byte_data (byte_data)
  );

  rxq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (byte_done),
    .push_data (byte_data),
    .pop       (pop),
    .rd_data   (pop_data),
    .empty     (q_empty),
    .level     (level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              done_q <= 1'b0;
    else if (last_byte)                      done_q <= 1'b1;
    else if (stat_wr && stat_wdata[DONE_BIT]) done_q <= 1'b0;
  end

  always_comb begin
    status                 = '0;
    status[DONE_BIT]       = done_q;
    fifo_status            = '0;
    fifo_status[EMPTY_BIT] = q_empty;
  end

  assign rx_busy    = busy;
  assign ack_strobe = byte_done;
  assign ack_is_nak = byte_done && nak_now;
endmodule

// File: rtl/rxq_burst_rx_chk.sv
module rxq_burst_rx_chk #(
  parameter int DEPTH   = 64,
  parameter int DW      = 8,
  parameter int REG_W   = 8,
  parameter int NAK_BIT = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ctl_wr,
  input logic [REG_W-1:0]           ctl_wdata,
  input logic                       pop,
  input logic [DW-1:0]              pop_data,
  input logic                       rx_busy,
  input logic                       ack_strobe,
  input logic                       ack_is_nak,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic [$clog2(DEPTH+1)-1:0] remain,
  input logic                       byte_done,
  input logic                       last_byte,
  input logic                       done_q
);
  // R2
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe |-> rx_busy);

  // R3
  nak_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strobe && ack_is_nak) |=> !rx_busy);

  // R4
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(last_byte));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && level == '0) |-> (pop_data == '0));

  // R7
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !rx_busy && ctl_wdata[NAK_BIT-1:0] == '0) |=> !rx_busy);

  // R9
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && !byte_done) |=> $stable(remain));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind rxq_burst_rx rxq_burst_rx_chk #(
  .DEPTH(DEPTH), .DW(DW), .REG_W(REG_W), .NAK_BIT(NAK_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_wdata  (ctl_wdata),
  .pop        (pop),
  .pop_data   (pop_data),
  .rx_busy    (rx_busy),
  .ack_strobe (ack_strobe),
  .ack_is_nak (ack_is_nak),
  .level      (level),
  .remain     (remain),
  .byte_done  (byte_done),
  .last_byte  (last_byte),
  .done_q     (done_q)
);

// File: tb/rxq_burst_rx_test.sv
module rxq_burst_rx_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       stat_wr = 1'b0;
  logic [7:0] stat_wdata = '0;
  logic [7:0] status, fifo_status;
  logic       pop = 1'b0;
  logic [7:0] pop_data;
  logic       bit_vld = 1'b0;
  logic       bit_val = 1'b0;
  logic       rx_busy, ack_strobe, ack_is_nak;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_burst_rx uut (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .status(status), .fifo_status(fifo_status),
    .pop(pop), .pop_data(pop_data),
    .bit_vld(bit_vld), .bit_val(bit_val),
    .rx_busy(rx_busy), .ack_strobe(ack_strobe), .ack_is_nak(ack_is_nak)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(posedge clk); #1 ctl_wr = 1'b0;
  endtask

  task automatic stat_write(input logic [7:0] v);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = v;
    @(posedge clk); #1 stat_wr = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic strobe, output logic nak);
    strobe = 1'b0; nak = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); bit_vld = 1'b1; bit_val = b[i];
      if (i == 0) begin
        #1 strobe = ack_strobe; nak = ack_is_nak;
      end
    end
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] exp);
    @(negedge clk); pop = 1'b1;
    #1 chk(req, pop_data, exp);
    @(posedge clk); #1 pop = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic t_reset;
    chk("R1 status", status, 8'h00);
    chk("R1 fifo_status", fifo_status, 8'h04);
    chk("R1 busy", rx_busy, 1'b0);
  endtask

  task automatic t_nak_burst;
    logic s, n;
    ctl_write(8'h83);
    chk("R2 busy after launch", rx_busy, 1'b1);
    send_byte(8'hA5, s, n); chk("R3 strobe b0", s, 1'b1); chk("R3 ack b0", n, 1'b0);
    send_byte(8'h3C, s, n); chk("R3 ack b1", n, 1'b0);
    send_byte(8'hF0, s, n); chk("R3 nak last", n, 1'b1);
    chk("R2 idle after burst", rx_busy, 1'b0);
    chk("R4 done set", status, 8'h10);
    chk("R5 not empty", fifo_status, 8'h00);
    pop_expect("R5 pop0", 8'hA5);
    pop_expect("R5 pop1", 8'h3C);
    pop_expect("R5 pop2", 8'hF0);
    chk("R5 empty", fifo_status, 8'h04);
  endtask

  task automatic t_ack_only;
    logic s, n;
    stat_write(8'h10);
    ctl_write(8'h02);
    send_byte(8'h81, s, n); chk("R3 ack nak-off b0", n, 1'b0);
    send_byte(8'h7E, s, n); chk("R3 ack nak-off last", n, 1'b0);
    chk("R4 done nak-off", status, 8'h10);
    pop_expect("R2 msb first 0", 8'h81);
    pop_expect("R2 msb first 1", 8'h7E);
  endtask

  task automatic t_w1c;
    stat_write(8'hEF);
    chk("R4 write 0 keeps", status, 8'h10);
    stat_write(8'h10);
    chk("R4 write 1 clears", status, 8'h00);
  endtask

  task automatic t_empty_pop;
    logic s, n;
    pop_expect("R6 empty pop zero", 8'h00);
    chk("R6 still empty", fifo_status, 8'h04);
    ctl_write(8'h81);
    send_byte(8'h5A, s, n);
    pop_expect("R6 order after empty pop", 8'h5A);
    chk("R6 empty again", fifo_status, 8'h04);
    stat_write(8'h10);
  endtask

  task automatic t_zero;
    ctl_write(8'h80);
    chk("R7 not busy", rx_busy, 1'b0);
    repeat (3) @(posedge clk);
    #1 chk("R7 no done", status, 8'h00);
  endtask

  task automatic t_idle_bits;
    logic s, n;
    send_byte(8'hC3, s, n);
    chk("R11 no strobe", s, 1'b0);
    chk("R11 queue empty", fifo_status, 8'h04);
    chk("R11 no done", status, 8'h00);
  endtask

  task automatic t_busy_launch;
    logic s, n;
    ctl_write(8'h02);
    send_byte(8'h11, s, n);
    ctl_write(8'h85);
    send_byte(8'h22, s, n);
    chk("R9 keeps nak setting", n, 1'b0);
    chk("R9 ends on old count", rx_busy, 1'b0);
    chk("R9 done", status, 8'h10);
    pop_expect("R9 pop0", 8'h11);
    pop_expect("R9 pop1", 8'h22);
    chk("R9 empty", fifo_status, 8'h04);
    stat_write(8'h10);
  endtask

  task automatic t_clamp_overflow;
    logic s, n;
    int bad = 0;
    ctl_write(8'h80 | 8'd100);
    for (int i = 0; i < 64; i++) begin
      send_byte(pat(i), s, n);
      if (n !== (i == 63)) bad++;
    end
    chk("R8 nak only on 64th", bad, 0);
    chk("R8 idle after 64", rx_busy, 1'b0);
    chk("R8 done after 64", status, 8'h10);
    stat_write(8'h10);
    ctl_write(8'h02);
    send_byte(8'hEE, s, n);
    send_byte(8'hDD, s, n);
    chk("R10 burst ends when full", rx_busy, 1'b0);
    chk("R10 done when full", status, 8'h10);
    for (int i = 0; i < 64; i++) pop_expect("R10 kept byte", pat(i));
    chk("R10 dropped bytes gone", fifo_status, 8'h04);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_nak_burst;
    t_ack_only;
    t_w1c;
    t_empty_pop;
    t_zero;
    t_idle_bits;
    t_busy_launch;
    t_clamp_overflow;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule